// File: doc/BRIEF.md
# External 16-bit Memory Bus Controller

This block turns internal memory requests of 8, 16 or 32 bits into cycles on an external bus with a 16-bit data path and separate address pins. It runs entirely on the fast core clock and keeps a phase counter that marks where each slower system bus period begins; that period is 1, 2 or 4 core cycles long, chosen by `ratio_sel`. Every external cycle is launched at a fixed core-cycle slot inside a system period, so the external device always sees cycles that line up with the system bus clock.

The address space is split into four blocks by the top two address bits. Each block has its own timing register that sets the start slot, how many core cycles before the end of the cycle the strobe is released, and a fixed number of extra system periods of wait. A 32-bit request becomes two external cycles, low halfword first. Byte writes use one of two lane strobes; halfword and word writes use both. When the access is complete the block raises a one-cycle done pulse with the assembled read data.

The controller is a four-state machine. ST_IDLE accepts a request (transition *accept*) and moves to ST_SYNC. ST_SYNC waits until the next core cycle falls on the block's start slot (transition *launch*) and moves to ST_ACTIVE. ST_ACTIVE counts the cycle length; at its last cycle it either returns to ST_SYNC for the upper half of a 32-bit access (transition *second_half*) or moves to ST_DONE (transition *finish*). ST_DONE pulses done for one cycle and returns to ST_IDLE (transition *release*).

Top module: `bc16_ext_bus`

## Requirements
- R1: After reset all chip selects, the read strobe and both write strobes are high (inactive), `ext_doe` is low and `req_ready` is high.
- R2: The first core cycle in which a chip select is low sits at slot S of a system period, where slot 0 is the cycle in which `sys_edge` is high and S is the block's start-slot field clamped to (ratio − 1).
- R3: A chip select stays low for exactly ratio × (wait field + 1) consecutive core cycles per external cycle.
- R4: The active strobe goes low together with the chip select and stays low for the cycle length minus the end-gap field clamped to (ratio − 1); strobes are never low while all chip selects are high.
- R5: Only the chip select indexed by request address bits [23:22] goes low; `ext_cs_n[i]` belongs to block i.
- R6: `ext_re_n` goes low only on reads; the write strobes go low and `ext_doe` goes high only on writes, and only inside a cycle.
- R7: An 8-bit write with address bit 0 = 0 drives `ext_we_n` = 2'b10 and the byte on `ext_dout[7:0]`; with address bit 0 = 1 it drives `ext_we_n` = 2'b01 and the byte on `ext_dout[15:8]`.
- R8: A 16-bit write drives `ext_we_n` = 2'b00 and the halfword on `ext_dout[15:0]`, with `ext_addr[0]` = 0.
- R9: A 32-bit access (size code 2'b10; 2'b11 acts the same) makes two external cycles separated by at least one core cycle with all chip selects high; the first has `ext_addr[1]` = 0 and carries data bits [15:0], the second has `ext_addr[1]` = 1 and carries bits [31:16]; each starts at slot S.
- R10: A 32-bit read returns {second halfword, first halfword}; each halfword is `ext_din` sampled in the last core cycle of its strobe.
- R11: An 8-bit read (size 2'b00) returns the byte of the lane chosen by address bit 0, zero-extended; a 16-bit read (size 2'b01) returns `ext_din` zero-extended.
- R12: `req_ready` is low from acceptance until done; a request presented meanwhile has no effect on the running access.
- R13: `rsp_done` is a single-cycle pulse in the core cycle right after the last chip-select-low cycle of the request.
- R14: `ratio_sel` 2'b00, 2'b01 and 2'b10/2'b11 select ratios 1, 2 and 4; `sys_edge` is high once every ratio core cycles. Timing register write data is {wait[3:0], end_gap[1:0], start_slot[1:0]}, all fields reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Core cycles per system period: 1, 2 or 4 |
| cfg_wr | input | 1 | Write strobe for a timing register |
| cfg_idx | input | 2 | Block whose timing register is written |
| cfg_wdata | input | 8 | {wait, end_gap, start_slot} |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_addr | input | 24 | Byte address; bits [23:22] pick the block |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with done |
| sys_edge | output | 1 | High in slot 0 of each system period |
| ext_addr | output | 24 | External byte address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | Drive enable for external data |
| ext_din | input | 16 | External read data |
| ext_cs_n | output | 4 | Active-low chip selects, one per block |
| ext_re_n | output | 1 | Active-low read strobe |
| ext_we_n | output | 2 | Active-low lane write strobes, bit i for lane i |

## Verification
A wrong state or counter shows as a chip select whose first low cycle lands on the wrong slot, or whose low run is a cycle long or short, visible within the very access that carries it. A lost half flag or a skipped ST_SYNC turns a 32-bit access into one cycle, two cycles with the same `ext_addr[1]`, or two cycles with no high gap between them, which the bench sees before done. Read capture in the wrong cycle or into the wrong half register shows as swapped or stale halfwords in `rsp_rdata` on the same done pulse, since the bench derives `ext_din` from `ext_addr`.

// File: rtl/bc16_pkg.sv
package bc16_pkg;

    localparam int BC_WAIT_W = 4;
    localparam int BC_SLOT_W = 2;
    localparam int BC_CFG_W  = BC_WAIT_W + 2 * BC_SLOT_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } bc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ACTIVE,
        ST_DONE
    } bc_state_e;

    typedef struct packed {
        logic [BC_WAIT_W-1:0] wait_n;
        logic [BC_SLOT_W-1:0] end_gap;
        logic [BC_SLOT_W-1:0] start_slot;
    } bc_timing_t;

endpackage

// File: rtl/bc16_phase_gen.sv
module bc16_phase_gen
    import bc16_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           ratio_sel,
    output logic [BC_SLOT_W-1:0] phase,
    output logic [BC_SLOT_W-1:0] phase_next,
    output logic [BC_SLOT_W-1:0] ratio_m1,
    output logic [1:0]           ratio_sh,
    output logic                 sys_edge
);

    always_comb begin
        unique case (ratio_sel)
            2'b00:   begin ratio_m1 = BC_SLOT_W'(0); ratio_sh = 2'd0; end
            2'b01:   begin ratio_m1 = BC_SLOT_W'(1); ratio_sh = 2'd1; end
            default: begin ratio_m1 = BC_SLOT_W'(3); ratio_sh = 2'd2; end
        endcase
    end

    assign phase_next = (phase >= ratio_m1) ? '0 : phase + 1'b1;
    assign sys_edge   = (phase == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase_next;
    end

endmodule

// File: rtl/bc16_cfg_regs.sv
module bc16_cfg_regs
    import bc16_pkg::*;
#(
    parameter int NBLK  = 4,
    localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [BC_CFG_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output bc_timing_t          rd_cfg
);

    bc_timing_t bank [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[b] <= '0;
            else if (cfg_wr && (cfg_idx == IDX_W'(b)))
                bank[b] <= bc_timing_t'(cfg_wdata);
        end
    end

    assign rd_cfg = bank[rd_idx];

endmodule

// File: rtl/bc16_lane_map.sv
module bc16_lane_map
    import bc16_pkg::*;
#(
    parameter int AW = 24
) (
    input  bc_size_e        size,
    input  logic [AW-1:0]   addr,
    input  logic            upper_half,
    input  logic [31:0]     wdata,
    input  logic            is_write,
    input  logic            active,
    input  logic            strobe_on,
    output logic [AW-1:0]   ext_addr,
    output logic [15:0]     ext_dout,
    output logic            ext_doe,
    output logic [1:0]      ext_we_n
);

    logic [1:0] lane_en;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                ext_addr = addr;
                ext_dout = {wdata[7:0], wdata[7:0]};
                lane_en  = addr[0] ? 2'b10 : 2'b01;
            end
            SZ_HALF: begin
                ext_addr = {addr[AW-1:1], 1'b0};
                ext_dout = wdata[15:0];
                lane_en  = 2'b11;
            end
            default: begin
                ext_addr = {addr[AW-1:2], upper_half, 1'b0};
                ext_dout = upper_half ? wdata[31:16] : wdata[15:0];
                lane_en  = 2'b11;
            end
        endcase
    end

    assign ext_doe  = active && is_write;
    assign ext_we_n = ~((strobe_on && is_write) ? lane_en : 2'b00);

endmodule

// File: rtl/bc16_ext_bus.sv
module bc16_ext_bus
    import bc16_pkg::*;
#(
    parameter int AW   = 24,
    parameter int NBLK = 4,
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int CNT_W = BC_WAIT_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ratio_sel,
    input  logic                cfg_wr,
    input  logic [BLK_W-1:0]    cfg_idx,
    input  logic [BC_CFG_W-1:0] cfg_wdata,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [AW-1:0]       req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_done,
    output logic [31:0]         rsp_rdata,
    output logic                sys_edge,
    output logic [AW-1:0]       ext_addr,
    output logic [15:0]         ext_dout,
    output logic                ext_doe,
    input  logic [15:0]         ext_din,
    output logic [NBLK-1:0]     ext_cs_n,
    output logic                ext_re_n,
    output logic [1:0]          ext_we_n
);

    bc_state_e            state, state_nx;
    logic [BC_SLOT_W-1:0] phase, phase_next, ratio_m1;
    logic [1:0]           ratio_sh;
    bc_timing_t           sel_cfg, cur_cfg;

    logic                 lat_wr;
    bc_size_e             lat_size;
    logic [AW-1:0]        lat_addr;
    logic [31:0]          lat_wdata;
    logic                 upper_half;
    logic [CNT_W-1:0]     cnt;
    logic [15:0]          rd_lo, rd_hi;

    logic [BC_SLOT_W-1:0] start_eff, gap_eff;
    logic [CNT_W-1:0]     len_m1, strobe_last;
    logic                 is_word, cyc_last, launch, active, strobe_on;
    logic [BLK_W-1:0]     lat_blk;

    bc16_phase_gen u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_sel  (ratio_sel),
        .phase      (phase),
        .phase_next (phase_next),
        .ratio_m1   (ratio_m1),
        .ratio_sh   (ratio_sh),
        .sys_edge   (sys_edge)
    );

    bc16_cfg_regs #(.NBLK(NBLK)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (cfg_wdata),
        .rd_idx     (req_addr[AW-1 -: BLK_W]),
        .rd_cfg     (sel_cfg)
    );

    // Timing derived from the latched block register and the live ratio
    assign start_eff   = (cur_cfg.start_slot > ratio_m1) ? ratio_m1 : cur_cfg.start_slot;
    assign gap_eff     = (cur_cfg.end_gap > ratio_m1) ? ratio_m1 : cur_cfg.end_gap;
    assign len_m1      = ((CNT_W'(cur_cfg.wait_n) + CNT_W'(1)) << ratio_sh) - CNT_W'(1);
    assign strobe_last = len_m1 - CNT_W'(gap_eff);
    assign is_word     = (lat_size == SZ_WORD) || (lat_size == SZ_WRD2);
    assign cyc_last    = (cnt == len_m1);
    assign launch      = (phase_next == start_eff);
    assign lat_blk     = lat_addr[AW-1 -: BLK_W];

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_SYNC;
            ST_SYNC:   if (launch)    state_nx = ST_ACTIVE;
            ST_ACTIVE: if (cyc_last)  state_nx = (is_word && !upper_half) ? ST_SYNC : ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Request latch, cycle counter and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_wr     <= 1'b0;
            lat_size   <= SZ_BYTE;
            lat_addr   <= '0;
            lat_wdata  <= '0;
            cur_cfg    <= '0;
            upper_half <= 1'b0;
            cnt        <= '0;
            rd_lo      <= '0;
            rd_hi      <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                lat_wr     <= req_write;
                lat_size   <= bc_size_e'(req_size);
                lat_addr   <= req_addr;
                lat_wdata  <= req_wdata;
                cur_cfg    <= sel_cfg;
                upper_half <= 1'b0;
            end
            if (state == ST_SYNC) cnt <= '0;
            if (state == ST_ACTIVE) begin
                cnt <= cnt + 1'b1;
                if (cnt == strobe_last && !lat_wr) begin
                    if (upper_half) rd_hi <= ext_din;
                    else            rd_lo <= ext_din;
                end
                if (cyc_last && is_word) upper_half <= 1'b1;
            end
        end
    end

    // Outputs
    assign active    = (state == ST_ACTIVE);
    assign strobe_on = active && (cnt <= strobe_last);

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_done  = (state == ST_DONE);
        ext_cs_n  = '1;
        if (active) ext_cs_n[lat_blk] = 1'b0;
        ext_re_n  = !(strobe_on && !lat_wr);
        unique case (lat_size)
            SZ_BYTE: rsp_rdata = {24'h0, lat_addr[0] ? rd_lo[15:8] : rd_lo[7:0]};
            SZ_HALF: rsp_rdata = {16'h0, rd_lo};
            default: rsp_rdata = {rd_hi, rd_lo};
        endcase
    end

    bc16_lane_map #(.AW(AW)) u_lane (
        .size       (lat_size),
        .addr       (lat_addr),
        .upper_half (upper_half),
        .wdata      (lat_wdata),
        .is_write   (lat_wr),
        .active     (active),
        .strobe_on  (strobe_on),
        .ext_addr   (ext_addr),
        .ext_dout   (ext_dout),
        .ext_doe    (ext_doe),
        .ext_we_n   (ext_we_n)
    );

endmodule

// File: rtl/bc16_ext_bus_chk.sv
module bc16_ext_bus_chk #(
    parameter int NBLK = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_done,
    input logic [NBLK-1:0] ext_cs_n,
    input logic            ext_re_n,
    input logic [1:0]      ext_we_n,
    input logic            ext_doe
);

    logic [NBLK-1:0] cs_act;
    logic            any_cs;
    assign cs_act = ~ext_cs_n;
    assign any_cs = (ext_cs_n != {NBLK{1'b1}});

    AST_ONE_CHIP_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_act) <= 1); // R5

    AST_READ_STROBE_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_re_n |-> (ext_we_n == 2'b11) && !ext_doe); // R6

    AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_re_n || ext_we_n != 2'b11) |-> any_cs); // R4

    AST_DRIVE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_doe |-> any_cs); // R6

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        any_cs |-> !req_ready); // R12

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R13

    AST_DONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(any_cs)); // R13

endmodule

bind bc16_ext_bus bc16_ext_bus_chk #(.NBLK(NBLK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .ext_cs_n  (ext_cs_n),
    .ext_re_n  (ext_re_n),
    .ext_we_n  (ext_we_n),
    .ext_doe   (ext_doe)
);

// File: tb/bc16_ext_bus_bench.sv
module bc16_ext_bus_bench;

    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ratio_sel = 2'b10;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        sys_edge;
    logic [AW-1:0] ext_addr;
    logic [15:0] ext_dout;
    logic        ext_doe;
    logic [15:0] ext_din;
    logic [3:0]  ext_cs_n;
    logic        ext_re_n;
    logic [1:0]  ext_we_n;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_f(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5AC3 ^ {a[23:16], a[23:16]};
    endfunction

    assign ext_din = mem_f(ext_addr);

    bc16_ext_bus u_bc16_ext_bus (
        .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sys_edge(sys_edge),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
        .ext_din(ext_din), .ext_cs_n(ext_cs_n), .ext_re_n(ext_re_n),
        .ext_we_n(ext_we_n)
    );

    // Measurements of the last access
    int          m_halves, m_ready_bad, m_done_cnt, m_wrong;
    int          m_start[2], m_cslen[2], m_stlen[2];
    logic [3:0]  m_csn[2];
    logic [AW-1:0] m_addr[2];
    logic [1:0]  m_wen[2];
    logic [15:0] m_dout[2];
    logic [31:0] m_rdata;
    bit          m_done_after_cs;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input int start, input int gap, input int wt);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 2'(idx);
        cfg_wdata = {4'(wt), 2'(gap), 2'(start)};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_access(input bit wr, input logic [1:0] sz,
                             input logic [AW-1:0] ad, input logic [31:0] wd,
                             input bit hold);
        int ph, guard;
        bit prev_act, act, strobe;
        m_halves = 0; m_ready_bad = 0; m_done_cnt = 0; m_wrong = 0;
        m_done_after_cs = 0; m_rdata = '0;
        for (int i = 0; i < 2; i++) begin
            m_start[i] = -1; m_cslen[i] = 0; m_stlen[i] = 0; m_csn[i] = 4'hF;
            m_addr[i] = '0; m_wen[i] = 2'b11; m_dout[i] = '0;
        end
        @(negedge clk);
        while (!sys_edge) @(negedge clk);
        ph = 0;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
        prev_act = 0;
        guard = 0;
        while (guard < 1000) begin
            @(negedge clk);
            guard++;
            ph = sys_edge ? 0 : ph + 1;
            if (!hold) req_valid = 1'b0;
            else begin
                req_addr = ad ^ {2'b10, {(AW-2){1'b0}}} ^ 24'h000100;
                req_write = !wr;
            end
            act = (ext_cs_n != 4'hF);
            strobe = !ext_re_n || (ext_we_n != 2'b11);
            if (act && !prev_act) begin
                m_halves++;
                if (m_halves <= 2) begin
                    m_start[m_halves-1] = ph;
                    m_csn[m_halves-1] = ext_cs_n;
                    m_addr[m_halves-1] = ext_addr;
                end
            end
            if (act && m_halves >= 1 && m_halves <= 2) begin
                m_cslen[m_halves-1]++;
                if (strobe) m_stlen[m_halves-1]++;
                if (ext_we_n != 2'b11) begin
                    m_wen[m_halves-1] = ext_we_n;
                    m_dout[m_halves-1] = ext_dout;
                end
            end
            if ((!wr && (ext_we_n != 2'b11 || ext_doe)) || (wr && !ext_re_n) ||
                (wr && act && !ext_doe))
                m_wrong++;
            if (act && req_ready) m_ready_bad++;
            if (rsp_done) begin
                m_done_cnt++;
                m_rdata = rsp_rdata;
                m_done_after_cs = prev_act;
                req_valid = 1'b0;
                @(negedge clk);
                if (rsp_done) m_done_cnt++;
                break;
            end
            prev_act = act;
        end
        req_valid = 1'b0;
    endtask

    function automatic int ratio_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 2 : 4;
    endfunction

    function automatic int clampv(input int v, input int r);
        return (v > r - 1) ? r - 1 : v;
    endfunction

    // Checks one external cycle against a block's timing
    task automatic chk_cycle(input int h, input int start, input int gap, input int wt,
                             input int blk, input string tag);
        int r;
        r = ratio_of(ratio_sel);
        chk(m_start[h] == clampv(start, r), {tag, " R2"}, "start slot", m_start[h], clampv(start, r));
        chk(m_cslen[h] == r * (wt + 1), {tag, " R3"}, "cs length", m_cslen[h], r * (wt + 1));
        chk(m_stlen[h] == r * (wt + 1) - clampv(gap, r), {tag, " R4"}, "strobe length",
            m_stlen[h], r * (wt + 1) - clampv(gap, r));
        chk(m_csn[h] == ~(4'b0001 << blk), {tag, " R5"}, "chip select", m_csn[h], ~(4'b0001 << blk));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ext_cs_n == 4'hF && ext_re_n && ext_we_n == 2'b11, "R1", "strobes at reset",
            {ext_cs_n, ext_re_n, ext_we_n}, 7'h7F);
        chk(!ext_doe && req_ready, "R1", "doe/ready at reset", {ext_doe, req_ready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && ext_cs_n == 4'hF, "R1", "idle after reset", {req_ready, ext_cs_n}, 5'h1F);
    endtask

    task automatic t_write_bytes;
        do_access(1'b1, 2'b00, 24'h000010, 32'h0000_00AB, 1'b0);
        chk_cycle(0, 1, 1, 0, 0, "byte lane0");
        chk(m_wen[0] == 2'b10, "R7", "lane0 we_n", m_wen[0], 2'b10);
        chk(m_dout[0][7:0] == 8'hAB, "R7", "lane0 data", m_dout[0][7:0], 8'hAB);
        chk(m_wrong == 0 && m_halves == 1, "R6", "byte write strobes", m_wrong, 0);
        do_access(1'b1, 2'b00, 24'h000011, 32'h0000_005E, 1'b0);
        chk(m_wen[0] == 2'b01, "R7", "lane1 we_n", m_wen[0], 2'b01);
        chk(m_dout[0][15:8] == 8'h5E, "R7", "lane1 data", m_dout[0][15:8], 8'h5E);
        chk(m_done_cnt == 1 && m_done_after_cs, "R13", "done pulse", m_done_cnt, 1);
    endtask

    task automatic t_write_half;
        do_access(1'b1, 2'b01, 24'h800021, 32'h0000_1234, 1'b0);
        chk_cycle(0, 2, 3, 2, 2, "half write");
        chk(m_wen[0] == 2'b00, "R8", "half we_n", m_wen[0], 2'b00);
        chk(m_dout[0] == 16'h1234, "R8", "half data", m_dout[0], 16'h1234);
        chk(m_addr[0][0] == 1'b0, "R8", "half addr bit0", m_addr[0][0], 0);
    endtask

    task automatic t_word;
        do_access(1'b1, 2'b10, 24'h400040, 32'hCAFE_BEEF, 1'b0);
        chk(m_halves == 2, "R9", "word write halves", m_halves, 2);
        chk_cycle(0, 3, 0, 1, 1, "word lo");
        chk_cycle(1, 3, 0, 1, 1, "word hi");
        chk(m_addr[0][1] == 1'b0 && m_addr[1][1] == 1'b1, "R9", "A1 order",
            {m_addr[0][1], m_addr[1][1]}, 2'b01);
        chk(m_dout[0] == 16'hBEEF && m_dout[1] == 16'hCAFE, "R9", "word data order",
            {m_dout[0], m_dout[1]}, 32'hBEEFCAFE);
        do_access(1'b0, 2'b11, 24'h400040, 32'h0, 1'b0);
        chk(m_halves == 2, "R9", "word read halves", m_halves, 2);
        chk(m_rdata == {mem_f(24'h400042), mem_f(24'h400040)}, "R10", "word read data",
            m_rdata, {mem_f(24'h400042), mem_f(24'h400040)});
        chk(m_done_cnt == 1 && m_done_after_cs, "R13", "word done pulse", m_done_cnt, 1);
        chk(m_wrong == 0, "R6", "word read strobes", m_wrong, 0);
    endtask

    task automatic t_read_small;
        do_access(1'b0, 2'b00, 24'hC00005, 32'h0, 1'b0);
        chk_cycle(0, 0, 2, 0, 3, "byte read");
        chk(m_rdata == {24'h0, mem_f(24'hC00005)[15:8]}, "R11", "byte read lane1",
            m_rdata, {24'h0, mem_f(24'hC00005)[15:8]});
        chk(m_wrong == 0, "R6", "read has no write strobe", m_wrong, 0);
        do_access(1'b0, 2'b00, 24'hC00004, 32'h0, 1'b0);
        chk(m_rdata == {24'h0, mem_f(24'hC00004)[7:0]}, "R11", "byte read lane0",
            m_rdata, {24'h0, mem_f(24'hC00004)[7:0]});
        do_access(1'b0, 2'b01, 24'hC00007, 32'h0, 1'b0);
        chk(m_rdata == {16'h0, mem_f(24'hC00006)}, "R11", "half read",
            m_rdata, {16'h0, mem_f(24'hC00006)});
    endtask

    task automatic t_busy;
        do_access(1'b0, 2'b10, 24'h800080, 32'h0, 1'b1);
        chk(m_ready_bad == 0, "R12", "ready while busy", m_ready_bad, 0);
        chk(m_halves == 2 && m_csn[0] == 4'b1011 && m_csn[1] == 4'b1011, "R12",
            "held request ignored", {m_halves, m_csn[1]}, 'h2B);
        chk(m_rdata == {mem_f(24'h800082), mem_f(24'h800080)}, "R12", "busy read data",
            m_rdata, {mem_f(24'h800082), mem_f(24'h800080)});
        chk(m_wrong == 0, "R6", "held write did not leak", m_wrong, 0);
    endtask

    task automatic t_ratio(input logic [1:0] sel);
        int cnt;
        ratio_sel = sel;
        @(negedge clk);
        while (!sys_edge) @(negedge clk);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!sys_edge && cnt < 10);
        chk(cnt == ratio_of(sel), "R14", "sys_edge period", cnt, ratio_of(sel));
        do_access(1'b0, 2'b01, 24'h400010, 32'h0, 1'b0);
        chk_cycle(0, 3, 0, 1, 1, "ratio blk1 R14");
        do_access(1'b1, 2'b10, 24'h800100, 32'h7654_3210, 1'b0);
        chk_cycle(0, 2, 3, 2, 2, "ratio blk2 lo R14");
        chk_cycle(1, 2, 3, 2, 2, "ratio blk2 hi R9");
        chk(m_dout[1] == 16'h7654, "R9", "ratio word hi data", m_dout[1], 16'h7654);
    endtask

    initial begin
        #(200000 * 10);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        cfg_write(0, 1, 1, 0);
        cfg_write(1, 3, 0, 1);
        cfg_write(2, 2, 3, 2);
        cfg_write(3, 0, 2, 0);
        t_write_bytes();
        t_write_half();
        t_word();
        t_read_small();
        t_busy();
        t_ratio(2'b01);
        t_ratio(2'b00);
        ratio_sel = 2'b10;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule